// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block executes one add, subtract or compare per accepted request, on operands of either 16 or 32 bits, and returns the arithmetic result together with a destination write strobe and a rebuilt status word. The caller supplies the current status word along with the operation. The block replaces the carry, parity, zero, sign and overflow positions in that word and passes every other bit through unchanged. The passed-through bits include the stored direction bit.

A compare is a subtraction whose difference is not written back. It rewrites the status bits exactly as a subtraction would, but holds the write strobe low. The unit has a single register stage. A request that is valid at one rising edge produces its answer, qualified by a valid output, after that edge. A new request can be accepted on every cycle.

Top module: `afg_unit`

## Requirements
- R1: Operation code 2'b00 (add) returns the sum of the two operands modulo 2 to the power of the selected width, with the write strobe high.
- R2: Operation code 2'b01 (subtract) returns the first operand minus the second modulo 2 to the power of the selected width, with the write strobe high.
- R3: Operation code 2'b10 (compare) updates the status bits exactly as a subtract would, and holds the write strobe low.
- R4: Status bit 0 (carry) is set by a carry out of the top bit of the selected width on an add, and by a borrow (first operand unsigned-less-than the second) on a subtract or compare. It is cleared otherwise.
- R5: Status bit 2 (parity) is set when bits 7..0 of the result contain an even number of ones, and cleared otherwise.
- R6: Status bit 6 (zero) is set when the result within the selected width is zero. Status bit 7 (sign) equals the top bit of the result within the selected width.
- R7: Status bit 11 (overflow) is set when the true signed result lies outside the signed range of the selected width. For an add this means both operands have the same sign and the result sign differs from them. For a subtract it means the operands have different signs and the result sign differs from the first operand.
- R8: All status bits other than 0, 2, 6, 7 and 11, including the direction bit at position 10, are copied unchanged from the incoming status word.
- R9: Width select 0 gives 16-bit operation. In that mode operand bits 31..16 are ignored and result bits 31..16 are zero. Width select 1 gives 32-bit operation.
- R10: The answer to a request accepted at a rising edge appears after that edge with the output valid high. A cycle without a request gives output valid low and the write strobe low. The write strobe is never high unless output valid is high.
- R11: Operation code 2'b11 is reserved. It returns a zero result, a low write strobe and the incoming status word unchanged.
- R12: While reset (active low) is asserted, output valid, the write strobe, the result and the status output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 2 | Operation: 00 add, 01 subtract, 10 compare, 11 reserved |
| in_wide | input | 1 | 1 selects 32-bit operation, 0 selects 16-bit |
| in_a | input | 32 | Destination (first) operand |
| in_b | input | 32 | Source (second) operand |
| in_flags | input | 32 | Current status word |
| out_valid | output | 1 | Answer present this cycle |
| out_result | output | 32 | Arithmetic result |
| out_wr_en | output | 1 | Destination write strobe |
| out_flags | output | 32 | Updated status word |

## Verification
The bench aims at the wrap points of both widths: all-ones plus one, the signed maximum plus one, zero minus one and the signed minimum minus one. At these points a carry taken from the wrong position, or an overflow rule borrowed from the add side, gives the wrong carry or overflow bit. Narrow requests carry junk in the upper operand halves, so a design that forgets to mask them gives a nonzero upper result or a wrong zero and sign bit. Compares of equal and unequal operands catch a design that writes back the difference. Status words full of ones and of random bits catch a design that clears or rewrites the direction bit or other untouched bits. A parity computed over the whole result instead of the low byte shows up as a parity mismatch on random data.

// File: rtl/afg_pkg.sv
package afg_pkg;

  typedef enum logic [1:0] {
    AFG_ADD = 2'b00,
    AFG_SUB = 2'b01,
    AFG_CMP = 2'b10,
    AFG_NOP = 2'b11
  } afg_op_e;

  // status word bit positions (decoded by downstream condition logic)
  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int DF_POS = 10;
  localparam int OF_POS = 11;

  function automatic logic even_ones8(input logic [7:0] b);
    return ~(^b);
  endfunction

  function automatic logic is_arith_flag(input int pos);
    return (pos == CF_POS) || (pos == PF_POS) || (pos == ZF_POS) ||
           (pos == SF_POS) || (pos == OF_POS);
  endfunction

  function automatic logic signed_ovf(input logic is_sub, input logic a_s,
                                      input logic b_s, input logic r_s);
    if (is_sub) return (a_s != b_s) && (r_s != a_s);
    return (a_s == b_s) && (r_s != a_s);
  endfunction

endpackage

// File: rtl/afg_addsub.sv
module afg_addsub #(
  parameter int W  = 32,
  parameter int NW = 16
) (
  input  logic         is_sub,
  input  logic         wide,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         a_msb,
  output logic         b_msb,
  output logic         r_msb
);
  localparam logic [W-1:0] NARROW_MASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic [W-1:0] mask;
  logic [W-1:0] am, bm;
  logic [W:0]   ext;

  always_comb begin
    mask = wide ? '1 : NARROW_MASK;
    am   = a & mask;
    bm   = b & mask;
    if (is_sub) ext = {1'b0, am} - {1'b0, bm};
    else        ext = {1'b0, am} + {1'b0, bm};
    res   = ext[W-1:0] & mask;
    carry = wide ? ext[W] : ext[NW];
    a_msb = wide ? am[W-1]  : am[NW-1];
    b_msb = wide ? bm[W-1]  : bm[NW-1];
    r_msb = wide ? res[W-1] : res[NW-1];
  end
endmodule

// File: rtl/afg_flag_gen.sv
module afg_flag_gen
  import afg_pkg::*;
#(
  parameter int W  = 32,
  parameter int FW = 32
) (
  input  logic          update,
  input  logic          is_sub,
  input  logic [W-1:0]  res,
  input  logic          carry,
  input  logic          a_msb,
  input  logic          b_msb,
  input  logic          r_msb,
  input  logic [FW-1:0] flags_in,
  output logic [FW-1:0] flags_out,
  output logic          ovf_evt,
  output logic          zero_evt
);
  logic [FW-1:0] fresh;

  assign ovf_evt  = signed_ovf(is_sub, a_msb, b_msb, r_msb);
  assign zero_evt = (res == '0);

  always_comb begin
    fresh         = '0;
    fresh[CF_POS] = carry;
    fresh[PF_POS] = even_ones8(res[7:0]);
    fresh[ZF_POS] = zero_evt;
    fresh[SF_POS] = r_msb;
    fresh[OF_POS] = ovf_evt;
  end

  for (genvar i = 0; i < FW; i++) begin : g_merge
    if (is_arith_flag(i)) begin : g_arith
      assign flags_out[i] = update ? fresh[i] : flags_in[i];
    end else begin : g_keep
      assign flags_out[i] = flags_in[i];
    end
  end
endmodule

// File: rtl/afg_unit.sv
module afg_unit
  import afg_pkg::*;
#(
  parameter int W  = 32,
  parameter int NW = 16,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic          in_wide,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [FW-1:0] in_flags,
  output logic          out_valid,
  output logic [W-1:0]  out_result,
  output logic          out_wr_en,
  output logic [FW-1:0] out_flags
);
  afg_op_e       op;
  logic          is_sub, is_arith, writes;
  logic [W-1:0]  sum;
  logic          carry, a_msb, b_msb, r_msb;
  logic [FW-1:0] flags_nx;
  logic          ovf_evt, zero_evt;
  afg_op_e       op_q;
  logic          wide_q;

  assign op       = afg_op_e'(in_op);
  assign is_sub   = (op == AFG_SUB) || (op == AFG_CMP);
  assign is_arith = (op != AFG_NOP);
  assign writes   = (op == AFG_ADD) || (op == AFG_SUB);

  afg_addsub #(.W(W), .NW(NW)) u_addsub (
    .is_sub(is_sub), .wide(in_wide), .a(in_a), .b(in_b),
    .res(sum), .carry(carry), .a_msb(a_msb), .b_msb(b_msb), .r_msb(r_msb)
  );

  afg_flag_gen #(.W(W), .FW(FW)) u_flags (
    .update(is_arith), .is_sub(is_sub), .res(sum), .carry(carry),
    .a_msb(a_msb), .b_msb(b_msb), .r_msb(r_msb), .flags_in(in_flags),
    .flags_out(flags_nx), .ovf_evt(ovf_evt), .zero_evt(zero_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr_en  <= 1'b0;
      out_flags  <= '0;
      op_q       <= AFG_NOP;
      wide_q     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_wr_en <= in_valid && writes;
      if (in_valid) begin
        out_result <= is_arith ? sum : '0;
        out_flags  <= flags_nx;
        op_q       <= op;
        wide_q     <= in_wide;
      end
    end
  end

  // compare never writes back
  p_cmp_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == AFG_CMP) |-> !out_wr_en);

  // strobe only with a valid answer
  p_wr_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> out_valid);

  // idle input yields idle output
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // direction bit passes through
  p_dir_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_flags[DF_POS] == $past(in_flags[DF_POS]));

  // zero flag agrees with the registered result
  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q != AFG_NOP && out_flags[ZF_POS]) |-> out_result == '0);

  // narrow mode leaves the upper half clear
  p_narrow_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_q) |-> out_result[W-1:NW] == '0);

  // reserved code leaves the status word alone
  p_nop_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == AFG_NOP) |-> out_flags == $past(in_flags));

endmodule

// File: tb/tb_afg_unit.sv
module tb_afg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic        in_wide = 1'b1;
  logic [31:0] in_a = '0, in_b = '0, in_flags = '0;
  logic        out_valid, out_wr_en;
  logic [31:0] out_result, out_flags;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] result;
    logic        wr;
    logic [31:0] flags;
    logic [1:0]  op;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  afg_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_wide(in_wide), .in_a(in_a), .in_b(in_b), .in_flags(in_flags),
    .out_valid(out_valid), .out_result(out_result), .out_wr_en(out_wr_en),
    .out_flags(out_flags)
  );

  function automatic exp_t model(input logic [1:0] op, input logic wide,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic [31:0] f);
    exp_t e;
    longint w    = wide ? 32 : 16;
    longint span = longint'(1) << w;
    longint half = span / 2;
    longint au   = longint'(a) % span;
    longint bu   = longint'(b) % span;
    longint sa   = (au >= half) ? au - span : au;
    longint sb_  = (bu >= half) ? bu - span : bu;
    longint r, st;
    logic   c;
    if (op == 2'b00) begin
      r = (au + bu) % span; c = (au + bu) >= span; st = sa + sb_;
    end else begin
      r = (au - bu + span) % span; c = au < bu; st = sa - sb_;
    end
    e.op    = op;
    e.flags = f;
    e.wr    = (op == 2'b00) || (op == 2'b01);
    if (op == 2'b11) begin
      e.result = '0;
    end else begin
      logic [31:0] r32;
      int ones;
      r32 = r[31:0];
      ones = 0;
      for (int i = 0; i < 8; i++) ones += r32[i];
      e.result    = r32;
      e.flags[0]  = c;
      e.flags[2]  = (ones % 2) == 0;
      e.flags[6]  = (r == 0);
      e.flags[7]  = r >= half;
      e.flags[11] = (st >= half) || (st < -half);
    end
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic wide,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] f);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_wide = wide; in_a = a; in_b = b; in_flags = f;
    sb.push_back(model(op, wide, a, b, f));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a = 32'hDEAD_BEEF;
    end
  endtask

  // monitor: compare each answer with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        chk("R10 unexpected answer", 32'd1, 32'd0);
      end else begin
        exp_t e;
        string rq;
        logic [31:0] keep;
        e = sb.pop_front();
        rq = (e.op == 2'b00) ? "R1 R9 result" : (e.op == 2'b11) ? "R11 result" :
             (e.op == 2'b01) ? "R2 R9 result" : "R3 result";
        chk(rq, out_result, e.result);
        chk((e.op == 2'b10) ? "R3 write strobe" : (e.op == 2'b11) ? "R11 write strobe"
            : "R1 R2 write strobe", {31'd0, out_wr_en}, {31'd0, e.wr});
        chk("R4 carry", {31'd0, out_flags[0]}, {31'd0, e.flags[0]});
        chk("R5 parity", {31'd0, out_flags[2]}, {31'd0, e.flags[2]});
        chk("R6 zero", {31'd0, out_flags[6]}, {31'd0, e.flags[6]});
        chk("R6 sign", {31'd0, out_flags[7]}, {31'd0, e.flags[7]});
        chk("R7 overflow", {31'd0, out_flags[11]}, {31'd0, e.flags[11]});
        keep = ~32'h0000_08C5;
        chk("R8 untouched bits", out_flags & keep, e.flags & keep);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 valid", {31'd0, out_valid}, 32'd0);
    chk("R12 strobe", {31'd0, out_wr_en}, 32'd0);
    chk("R12 result", out_result, 32'd0);
    chk("R12 flags", out_flags, 32'd0);
    rst_n = 1'b1;
    idle(2);

    // wrap points, 32-bit
    drive(2'b00, 1, 32'hFFFF_FFFF, 32'h1, 32'h0);            // R1 R4 R6
    drive(2'b00, 1, 32'h7FFF_FFFF, 32'h1, 32'h0000_0400);    // R7 with direction set
    drive(2'b01, 1, 32'h0, 32'h1, 32'h0);                    // R2 R4 borrow
    drive(2'b01, 1, 32'h8000_0000, 32'h1, 32'hFFFF_FFFF);    // R7 sub, R8
    drive(2'b00, 1, 32'h1, 32'h0, 32'h0);                    // R5 odd parity
    // compares
    drive(2'b10, 1, 32'd5, 32'd5, 32'h0);                    // R3 equal
    drive(2'b10, 1, 32'd3, 32'd5, 32'hFFFF_F73A);            // R3 less
    // 16-bit with junk upper halves
    drive(2'b00, 0, 32'h1234_FFFF, 32'hABCD_0001, 32'h0);    // R9 wrap
    drive(2'b01, 0, 32'hFFFF_8000, 32'h5555_0001, 32'h0);    // R9 R7
    drive(2'b00, 0, 32'h0000_7FFF, 32'hFFFF_0001, 32'h0);    // R9 R7 add
    drive(2'b10, 0, 32'hAAAA_0010, 32'h0000_0010, 32'h0);    // R9 R3 zero
    // reserved code
    drive(2'b11, 1, 32'h1234_5678, 32'h9, 32'h0000_FFFF);    // R11
    idle(3);
    // R10 idle gives no answer
    chk("R10 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R10 idle strobe", {31'd0, out_wr_en}, 32'd0);

    // random traffic with gaps
    for (int k = 0; k < 400; k++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      drive(op, 1'($urandom_range(0, 1)), $urandom, $urandom, $urandom);
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    idle(4);
    chk("R10 scoreboard drained", sb.size(), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule